// File: doc/BRIEF.md
# Receive Frame Check Sequence Verifier and Stripper

This block sits on the byte-wide receive stream of an Ethernet MAC, after preamble removal. Each frame arrives one byte per valid cycle, with the last byte marked by `inLast`; the final four bytes of every frame are the CRC-32 frame check sequence, least significant byte first. The block computes the CRC over the bytes that come before the check sequence. It then sorts the frame into one of three classes. The frame is good when the received word equals the correct value. It is stomped when the received word is the exact bitwise complement of the correct value, which is how an upstream stage deliberately poisons a frame. Any other mismatch is a bad check sequence.

A four-entry byte delay line holds back the newest bytes. When stripping is enabled, the end-of-frame mark can therefore move onto the last payload byte and the check bytes are dropped. Frames of eight bytes or fewer are never stripped. When a frame is not stripped, the held bytes drain out over the four cycles after the frame ends. The block has no backpressure. The source must send frames of at least four bytes and leave at least four idle cycles after every `inLast` beat. A real line's inter-frame gap gives far more than that.

Top module: `rx_fcs_checker`

## Requirements
- R1: The check sequence is the standard Ethernet CRC-32: reflected polynomial 0xEDB88320, register preset to all ones, result inverted, sent as four bytes with bits 7:0 of the inverted result first. A frame whose trailing word matches produces no status pulse and leaves `outUser` low.
- R2: A frame whose trailing word matches neither the correct value nor its complement raises `badFcsPulse` for one cycle, in the cycle after the `inLast` beat is accepted. When `ignoreFcs` is low, the frame's final output beat carries `outUser` = 1.
- R3: A frame whose trailing word equals the bitwise complement of the correct value raises `stompedFcsPulse`, and not `badFcsPulse`, for one cycle in the cycle after the `inLast` beat. When `ignoreFcs` is low, the final output beat carries `outUser` = 1.
- R4: `badFcsPulse` and `stompedFcsPulse` are never high in the same cycle, and each one lasts one cycle per frame.
- R5: With `deleteFcs` = 1 and a frame longer than 8 bytes, the output holds exactly the bytes before the check sequence, in order. `outLast` is on the last of them, in the cycle after the input `inLast` beat.
- R6: With `deleteFcs` = 1 and a frame of 8 bytes or fewer, the whole frame, including the check bytes, is passed on unchanged. `outLast` comes 5 cycles after the input `inLast` beat.
- R7: With `deleteFcs` = 0, every frame is passed on whole and in order, with exactly one `outLast` on its final byte, 5 cycles after the input `inLast` beat.
- R8: With `ignoreFcs` = 1, `outUser` stays low for every frame, while both status pulses still behave as in R2 and R3.
- R9: `outUser` is only ever high together with `outLast`, and `outLast` only together with `outValid`.
- R10: After reset, `outValid`, `outLast`, `outUser` and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| deleteFcs | input | 1 | Remove check bytes from frames longer than 8 bytes; change only during reset |
| ignoreFcs | input | 1 | Suppress the error mark on `outUser` |
| inData | input | 8 | Received byte |
| inValid | input | 1 | `inData` carries a byte this cycle |
| inLast | input | 1 | This byte ends the frame |
| outData | output | 8 | Forwarded byte |
| outValid | output | 1 | `outData` carries a byte this cycle |
| outLast | output | 1 | Final byte of the forwarded frame |
| outUser | output | 1 | Frame failed its check (on the final beat only) |
| badFcsPulse | output | 1 | One-cycle pulse: frame had a wrong check sequence |
| stompedFcsPulse | output | 1 | One-cycle pulse: frame had a complemented check sequence |

## Verification
If the delay line is corrupted, or the byte counter loses its place, the fault shows in the same frame. Bytes come out reordered or missing, or `outLast` lands at the wrong index. Both are caught before the next frame begins. A CRC register that is not preset again at a frame boundary passes the first frame. It then misclassifies the second, so the good, bad and complemented cases are each swept over a range of lengths. Each classification is checked against the pulse lines and `outUser` in that frame's closing cycles, and the mark's cycle number is checked against the stripping rule.

// File: rtl/rfcs_pkg.sv
package rfcs_pkg;
  localparam int BYTE_W = 8;
  localparam int CRC_W = 32;
  localparam int FCS_BYTES = CRC_W / BYTE_W;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_PRESET = '1;

  // Strobes from control to datapath for the current cycle.
  typedef struct packed {
    logic push;      // accept inData into the delay line
    logic eat;       // oldest held byte leaves and enters the CRC
    logic drain;     // shift the line with no new byte
    logic emit;      // drive the oldest held byte downstream
    logic markLast;  // the emitted byte ends the output frame
    logic markUser;  // the emitted byte carries the error mark
    logic restart;   // preset the CRC for the next frame
  } ctrl_t;

  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < BYTE_W; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ CRC_POLY_REFL;
      else r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rfcs_datapath.sv
module rfcs_datapath
  import rfcs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [BYTE_W-1:0] inData,
  output logic              fcsGood,
  output logic              fcsStomped,
  output logic [BYTE_W-1:0] outData,
  output logic              outValid,
  output logic              outLast,
  output logic              outUser
);
  localparam int OLDEST = FCS_BYTES - 1;

  logic [BYTE_W-1:0] line [FCS_BYTES];
  logic [CRC_W-1:0] crcReg;
  logic [CRC_W-1:0] crcSeen;
  logic [CRC_W-1:0] fcsWord;

  // line[0] is the newest byte, line[OLDEST] the next to leave
  always_ff @(posedge clk) begin
    if (!rstN) line[0] <= '0;
    else if (ctrl.push) line[0] <= inData;
    else if (ctrl.drain) line[0] <= '0;
  end

  for (genvar k = 1; k < FCS_BYTES; k++) begin : gShift
    always_ff @(posedge clk) begin
      if (!rstN) line[k] <= '0;
      else if (ctrl.push || ctrl.drain) line[k] <= line[k-1];
    end
  end

  // Received check word, first received byte in the low bits
  for (genvar k = 0; k < FCS_BYTES - 1; k++) begin : gWord
    assign fcsWord[BYTE_W*k +: BYTE_W] = line[FCS_BYTES-2-k];
  end
  assign fcsWord[CRC_W-1 -: BYTE_W] = inData;

  always_ff @(posedge clk) begin
    if (!rstN || ctrl.restart) crcReg <= CRC_PRESET;
    else if (ctrl.eat) crcReg <= crcStep(crcReg, line[OLDEST]);
  end

  assign crcSeen = ctrl.eat ? crcStep(crcReg, line[OLDEST]) : crcReg;
  assign fcsGood = (fcsWord == ~crcSeen);
  assign fcsStomped = (fcsWord == crcSeen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData <= '0;
      outLast <= 1'b0;
      outUser <= 1'b0;
    end else begin
      outValid <= ctrl.emit;
      outData <= ctrl.emit ? line[OLDEST] : '0;
      outLast <= ctrl.emit && ctrl.markLast;
      outUser <= ctrl.emit && ctrl.markUser;
    end
  end

  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  assert_user_last_R9: assert property (@(posedge clk) disable iff (!rstN)
    outUser |-> outLast);
endmodule

// File: rtl/rfcs_control.sv
module rfcs_control
  import rfcs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int KEEP_MAX = 8
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  inValid,
  input  logic  inLast,
  input  logic  deleteFcs,
  input  logic  ignoreFcs,
  input  logic  fcsGood,
  input  logic  fcsStomped,
  output ctrl_t ctrl,
  output logic  badFcsPulse,
  output logic  stompedFcsPulse
);
  localparam int DRAIN_W = $clog2(FCS_BYTES + 1);
  localparam logic [DRAIN_W-1:0] DRAIN_LOAD = DRAIN_W'(FCS_BYTES);
  localparam logic [LEN_W:0] KEEP_LIM = (LEN_W+1)'(KEEP_MAX);
  localparam logic [LEN_W-1:0] FULL_AT = LEN_W'(FCS_BYTES);

  logic [LEN_W-1:0] byteCnt;
  logic [DRAIN_W-1:0] drainCnt;
  logic errHeld;
  logic beat, endBeat, lineFull, stripNow, errNow, drainEnd;
  logic [LEN_W:0] frameLen;

  assign beat = inValid && (drainCnt == '0);
  assign endBeat = beat && inLast;
  assign lineFull = byteCnt >= FULL_AT;
  assign frameLen = {1'b0, byteCnt} + 1'b1;
  assign stripNow = deleteFcs && (frameLen > KEEP_LIM);
  assign errNow = !ignoreFcs && !fcsGood;
  assign drainEnd = (drainCnt == DRAIN_W'(1));

  always_comb begin
    ctrl = '0;
    ctrl.push = beat;
    ctrl.eat = beat && lineFull;
    ctrl.drain = (drainCnt != '0);
    ctrl.emit = ctrl.eat || ctrl.drain;
    ctrl.restart = endBeat;
    if (endBeat && stripNow) begin
      ctrl.markLast = 1'b1;
      ctrl.markUser = errNow;
    end else if (drainEnd) begin
      ctrl.markLast = 1'b1;
      ctrl.markUser = errHeld;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCnt <= '0;
      drainCnt <= '0;
      errHeld <= 1'b0;
      badFcsPulse <= 1'b0;
      stompedFcsPulse <= 1'b0;
    end else begin
      if (endBeat) byteCnt <= '0;
      else if (beat && byteCnt != '1) byteCnt <= byteCnt + 1'b1;
      if (endBeat && !stripNow) drainCnt <= DRAIN_LOAD;
      else if (drainCnt != '0) drainCnt <= drainCnt - 1'b1;
      if (endBeat) errHeld <= errNow;
      badFcsPulse <= endBeat && !fcsGood && !fcsStomped;
      stompedFcsPulse <= endBeat && fcsStomped;
    end
  end

  assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(badFcsPulse && stompedFcsPulse));
  assert_bad_after_last_R2: assert property (@(posedge clk) disable iff (!rstN)
    badFcsPulse |-> $past(inValid && inLast));
  assert_stomp_after_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    stompedFcsPulse |-> $past(inValid && inLast));
  assert_drain_emits_R7: assert property (@(posedge clk) disable iff (!rstN)
    (drainCnt != '0) |-> !ctrl.eat);
endmodule

// File: rtl/rx_fcs_checker.sv
module rx_fcs_checker
  import rfcs_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int KEEP_MAX = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       deleteFcs,
  input  logic       ignoreFcs,
  input  logic [7:0] inData,
  input  logic       inValid,
  input  logic       inLast,
  output logic [7:0] outData,
  output logic       outValid,
  output logic       outLast,
  output logic       outUser,
  output logic       badFcsPulse,
  output logic       stompedFcsPulse
);
  ctrl_t ctrl;
  logic fcsGood, fcsStomped;

  rfcs_control #(.LEN_W(LEN_W), .KEEP_MAX(KEEP_MAX)) u_control (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .deleteFcs(deleteFcs), .ignoreFcs(ignoreFcs),
    .fcsGood(fcsGood), .fcsStomped(fcsStomped), .ctrl(ctrl),
    .badFcsPulse(badFcsPulse), .stompedFcsPulse(stompedFcsPulse)
  );

  rfcs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inData(inData),
    .fcsGood(fcsGood), .fcsStomped(fcsStomped),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outUser(outUser)
  );

  assert_ignore_no_user_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ignoreFcs && $past(ignoreFcs)) |-> !outUser);
endmodule

// File: tb/rx_fcs_checker_tb.sv
module rx_fcs_checker_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic deleteFcs = 1'b0, ignoreFcs = 1'b0;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0;
  logic [7:0] outData;
  logic outValid, outLast, outUser, badFcsPulse, stompedFcsPulse;

  int checks = 0, errors = 0, cycle = 0;
  logic [7:0] gotQ[$];
  int lastCount, lastIdx, lastCycle, lastUser, strayUser;
  int badCount, stompCount, pulseCycle;

  always #2 clk = ~clk;
  always @(posedge clk) cycle++;

  rx_fcs_checker u_dut (
    .clk(clk), .rstN(rstN), .deleteFcs(deleteFcs), .ignoreFcs(ignoreFcs),
    .inData(inData), .inValid(inValid), .inLast(inLast),
    .outData(outData), .outValid(outValid), .outLast(outLast), .outUser(outUser),
    .badFcsPulse(badFcsPulse), .stompedFcsPulse(stompedFcsPulse)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (outValid) begin
        gotQ.push_back(outData);
        if (outLast) begin
          lastCount++; lastIdx = gotQ.size() - 1; lastCycle = cycle;
          lastUser = int'(outUser);
        end else if (outUser) strayUser++;
      end else if (outUser || outLast) strayUser++;
      if (badFcsPulse) begin badCount++; pulseCycle = cycle; end
      if (stompedFcsPulse) begin stompCount++; pulseCycle = cycle; end
    end
  end

  function automatic logic [31:0] modelCrc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (b[i]) begin
      c = c ^ {24'h0, b[i]};
      for (int s = 0; s < 8; s++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input logic del, input logic ign);
    rstN = 1'b0; deleteFcs = del; ignoreFcs = ign;
    inValid = 1'b0; inLast = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  // kind: 0 good, 1 bad, 2 stomped
  task automatic sendFrame(input int len, input int kind);
    logic [7:0] fr[$];
    logic [7:0] pay[$];
    logic [31:0] reg32, word;
    int tc, expN, expLastCycle, dataOk;
    bit strip;
    string dReq;
    for (int i = 0; i < len - 4; i++) pay.push_back(8'($urandom));
    reg32 = modelCrc(pay);
    if (kind == 0) word = ~reg32;
    else if (kind == 1) word = ~reg32 ^ (32'h1 << (len % 32));
    else word = reg32;
    fr = pay;
    for (int k = 0; k < 4; k++) fr.push_back(word[8*k +: 8]);
    gotQ.delete();
    lastCount = 0; lastIdx = -1; lastCycle = -1; lastUser = -1; strayUser = 0;
    badCount = 0; stompCount = 0; pulseCycle = -1; tc = 0;
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      inValid = 1'b1; inData = fr[i]; inLast = (i == len - 1);
      if (i == len - 1) tc = cycle;
    end
    @(posedge clk); #1 inValid = 1'b0; inLast = 1'b0; inData = '0;
    repeat (9) @(posedge clk);
    @(negedge clk);
    strip = deleteFcs && (len > 8);
    dReq = strip ? "R5" : (deleteFcs ? "R6" : "R7");
    expN = strip ? len - 4 : len;
    expLastCycle = strip ? tc + 1 : tc + 5;
    dataOk = (gotQ.size() == expN);
    if (dataOk) for (int i = 0; i < expN; i++) if (gotQ[i] !== fr[i]) dataOk = 0;
    check(dataOk != 0, dReq, "byte count/content", gotQ.size(), expN);
    check(lastCount == 1 && lastIdx == expN - 1, dReq, "last index", lastIdx, expN - 1);
    check(lastCycle == expLastCycle, dReq, "last cycle", lastCycle, expLastCycle);
    check(strayUser == 0, "R9", "stray user/last", strayUser, 0);
    if (ignoreFcs) check(lastUser == 0, "R8", "user ignored", lastUser, 0);
    else if (kind == 0) check(lastUser == 0, "R1", "user on good", lastUser, 0);
    else if (kind == 1) check(lastUser == 1, "R2", "user on bad", lastUser, 1);
    else check(lastUser == 1, "R3", "user on stomped", lastUser, 1);
    check(badCount == (kind == 1 ? 1 : 0), kind == 1 ? "R2" : "R4", "bad pulses",
          badCount, kind == 1 ? 1 : 0);
    check(stompCount == (kind == 2 ? 1 : 0), kind == 2 ? "R3" : "R4", "stomp pulses",
          stompCount, kind == 2 ? 1 : 0);
    if (kind != 0) check(pulseCycle == tc + 1, "R4", "pulse cycle", pulseCycle, tc + 1);
    else check(pulseCycle == -1, "R1", "no pulse on good", pulseCycle, -1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    doReset(1'b0, 1'b0);
    @(negedge clk);
    check(!outValid && !outLast && !outUser && !badFcsPulse && !stompedFcsPulse,
          "R10", "reset outputs", int'({outValid, outLast, outUser, badFcsPulse, stompedFcsPulse}), 0);
    for (int cfg = 0; cfg < 4; cfg++) begin
      doReset(cfg[0], cfg[1]);
      for (int len = 4; len <= 20; len++)
        for (int kind = 0; kind < 3; kind++) sendFrame(len, kind);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule